// File: doc/BRIEF.md
# Multiplexed Seven-Segment Scan Controller

This block drives a time-multiplexed seven-segment LED display of up to eight digits. It lights one digit at a time by activating a single common line and presenting that digit's segment byte on the segment lines. It steps through the configured digits in ascending order and repeats the scan without pause. Each digit stays selected for a programmable lighting period. A brightness setting blanks the early part of that period.

The block runs on a system clock that is qualified by an operating-clock enable. A module enable starts and stops the scan. A debug-halt input freezes the scan unless the run-in-debug control is set. Static configuration inputs set the following:
- the period divider;
- the index of the last digit;
- the common type, which fixes both output polarities;
- how idle common and segment lines are driven;
- the brightness level.

Software fills an internal bank of segment bytes, one per digit, through a simple write port. The block takes a snapshot of a digit's byte at the start of each visit to that digit.

Top module: `seg_scan_ctrl`

## Requirements
- R1: Each digit is selected for exactly (lp_div + 1) × 8 advancing clock cycles, where lp_div ranges from 0 to 255.
- R2: Digits are visited 0, 1, …, last_dig, then 0 again, so last_dig + 1 digits are scanned. A full scan lasts the lighting period × (last_dig + 1).
- R3: At most one common line is active at any time. While a digit is lit, each segment line is active exactly where the snapshot byte for that digit has a 1 (bit j drives seg_o[j]).
- R4: An advancing cycle requires clk_en = 1 and also requires either dbg_halt = 0 or run_in_dbg = 1. In any other cycle the scan position and the outputs hold. Scanning resumes from that point.
- R5: When com_mode = 0, an active common is driven 0 and an active segment is driven 1. When com_mode = 1, an active common is driven 1 and an active segment is driven 0. An inactive line always carries the opposite level.
- R6: If com_off_hiz = 0, every com_oe bit is 1. If com_off_hiz = 1, com_oe is 1 only for the active common. The same rule links seg_off_hiz, seg_oe and the active segments.
- R7: For brightness b (0 to 3), all lines are inactive during the first (3 − b) of the eight equal slices of each digit period. They light normally for the remaining slices.
- R8: While mod_en = 0, no common or segment line is active and the scan returns to digit 0, slice 0. When mod_en rises, digit 0 starts its period at once.
- R9: A change of lp_div or last_dig during a scan first takes effect at the next digit boundary. The period already under way keeps its length, and the wrap point is decided at the boundary.
- R10: A write to the bank during a digit's period does not change the segments shown in that period. The new byte appears the next time that digit is selected.
- R11: After reset with mod_en = 0 and com_mode = 0, com_o = 8'hFF, seg_o = 8'h00, and both enable vectors are all ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Operating-clock qualifier; the scan advances only when 1 |
| mod_en | input | 1 | Module enable; 0 blanks the display and rewinds the scan |
| dbg_halt | input | 1 | Debug mode active |
| run_in_dbg | input | 1 | Keeps scanning while dbg_halt is 1 |
| lp_div | input | 8 | Lighting-period divider; the period is (lp_div+1)×8 cycles |
| last_dig | input | 3 | Index of the last scanned digit |
| com_mode | input | 1 | Common type; selects output polarities |
| com_off_hiz | input | 1 | 1 releases idle commons (com_oe low) |
| seg_off_hiz | input | 1 | 1 releases idle segments (seg_oe low) |
| bright | input | 2 | Brightness level 0 (dimmest) to 3 (full) |
| wr_en | input | 1 | Bank write strobe |
| wr_addr | input | 3 | Digit index to write |
| wr_data | input | 8 | Segment byte to write |
| com_o | output | 8 | Common line levels |
| com_oe | output | 8 | Common line drive enables |
| seg_o | output | 8 | Segment line levels |
| seg_oe | output | 8 | Segment line drive enables |

## Verification
The two functions that can fall in the same cycle are the digit boundary and the freeze from debug halt (or a low clk_en). A configuration change can also land on that same boundary. The bench raises dbg_halt in the final cycle of a digit, which is the cycle whose edge would switch to the next digit. It then checks that the old digit stays on for the whole halt and that the switch happens on the first edge after release. It also changes lp_div and last_dig in the middle of a period and confirms that the running period keeps its old length and that the wrap uses the new count. Each result is compared with a position model built from the requirements.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;
   localparam int SLICES  = 8;
   localparam int SLICE_W = $clog2(SLICES);

   // number of blanked leading slices for a 2-bit brightness level
   function automatic logic [SLICE_W-1:0] first_lit_slice(input logic [1:0] lvl);
      return SLICE_W'(2'd3 - lvl);
   endfunction
endpackage

// File: rtl/seg_scan_timer.sv
module seg_scan_timer
   import seg_scan_pkg::*;
#(
   parameter int DIV_W = 8,
   parameter int IDX_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               mod_en,
   input  logic               step,
   input  logic [DIV_W-1:0]   div_in,
   input  logic [IDX_W-1:0]   last_idx,
   output logic [SLICE_W-1:0] slice,
   output logic [IDX_W-1:0]   idx,
   output logic [IDX_W-1:0]   nxt_idx,
   output logic               bound
);
   logic [DIV_W-1:0] pre_q;
   logic [DIV_W-1:0] div_q;
   logic             slice_end;

   assign slice_end = (pre_q == div_q);
   assign bound     = step && slice_end && (slice == SLICE_W'(SLICES - 1));
   assign nxt_idx   = (idx >= last_idx) ? '0 : idx + 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         div_q <= '0;
         slice <= '0;
         idx   <= '0;
      end else if (!mod_en) begin
         pre_q <= '0;
         slice <= '0;
         idx   <= '0;
         div_q <= div_in;
      end else if (step) begin
         if (slice_end) begin
            pre_q <= '0;
            slice <= slice + 1'b1;
            if (bound) begin
               idx   <= nxt_idx;
               div_q <= div_in;
            end
         end else begin
            pre_q <= pre_q + 1'b1;
         end
      end
   end
endmodule

// File: rtl/seg_scan_bank.sv
module seg_scan_bank #(
   parameter int NUM_DIG = 8,
   parameter int SEG_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mod_en,
   input  logic             wr_en,
   input  logic [IDX_W-1:0] wr_addr,
   input  logic [SEG_W-1:0] wr_data,
   input  logic             bound,
   input  logic [IDX_W-1:0] nxt_idx,
   output logic [SEG_W-1:0] seg_hold
);
   logic [SEG_W-1:0] mem [NUM_DIG];

   for (genvar g = 0; g < NUM_DIG; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (wr_en && (wr_addr == IDX_W'(g)))
            mem[g] <= wr_data;
      end
   end

   // snapshot taken when a digit's period begins
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         seg_hold <= '0;
      else if (!mod_en)
         seg_hold <= mem[0];
      else if (bound)
         seg_hold <= mem[nxt_idx];
   end
endmodule

// File: rtl/seg_scan_drive.sv
module seg_scan_drive
   import seg_scan_pkg::*;
#(
   parameter int NUM_DIG = 8,
   parameter int SEG_W   = 8,
   parameter int IDX_W   = 3
) (
   input  logic               mod_en,
   input  logic               com_mode,
   input  logic               com_off_hiz,
   input  logic               seg_off_hiz,
   input  logic [1:0]         bright,
   input  logic [SLICE_W-1:0] slice,
   input  logic [IDX_W-1:0]   idx,
   input  logic [SEG_W-1:0]   seg_hold,
   output logic [NUM_DIG-1:0] com_o,
   output logic [NUM_DIG-1:0] com_oe,
   output logic [SEG_W-1:0]   seg_o,
   output logic [SEG_W-1:0]   seg_oe
);
   logic lit;
   logic com_on_lvl;
   logic seg_on_lvl;

   assign lit        = mod_en && (slice >= first_lit_slice(bright));
   assign com_on_lvl = com_mode;
   assign seg_on_lvl = ~com_mode;

   for (genvar c = 0; c < NUM_DIG; c++) begin : g_com
      logic act;
      assign act       = lit && (idx == IDX_W'(c));
      assign com_o[c]  = act ? com_on_lvl : ~com_on_lvl;
      assign com_oe[c] = act || !com_off_hiz;
   end

   for (genvar s = 0; s < SEG_W; s++) begin : g_seg
      logic act;
      assign act       = lit && seg_hold[s];
      assign seg_o[s]  = act ? seg_on_lvl : ~seg_on_lvl;
      assign seg_oe[s] = act || !seg_off_hiz;
   end
endmodule

// File: rtl/seg_scan_ctrl.sv
module seg_scan_ctrl
   import seg_scan_pkg::*;
#(
   parameter int NUM_DIG = 8,
   parameter int SEG_W   = 8,
   parameter int DIV_W   = 8,
   localparam int IDX_W  = $clog2(NUM_DIG)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clk_en,
   input  logic               mod_en,
   input  logic               dbg_halt,
   input  logic               run_in_dbg,
   input  logic [DIV_W-1:0]   lp_div,
   input  logic [IDX_W-1:0]   last_dig,
   input  logic               com_mode,
   input  logic               com_off_hiz,
   input  logic               seg_off_hiz,
   input  logic [1:0]         bright,
   input  logic               wr_en,
   input  logic [IDX_W-1:0]   wr_addr,
   input  logic [SEG_W-1:0]   wr_data,
   output logic [NUM_DIG-1:0] com_o,
   output logic [NUM_DIG-1:0] com_oe,
   output logic [SEG_W-1:0]   seg_o,
   output logic [SEG_W-1:0]   seg_oe
);
   if (NUM_DIG < 2 || (1 << IDX_W) != NUM_DIG) begin : g_bad_dig
      $error("NUM_DIG must be a power of two, at least 2");
   end
   if (SEG_W < 7) begin : g_bad_seg
      $error("SEG_W must cover seven segments");
   end
   if (DIV_W < 1) begin : g_bad_div
      $error("DIV_W must be positive");
   end

   logic               step;
   logic               dig_bound;
   logic [SLICE_W-1:0] cur_slice;
   logic [IDX_W-1:0]   cur_idx;
   logic [IDX_W-1:0]   nxt_idx;
   logic [SEG_W-1:0]   seg_hold;

   assign step = clk_en && mod_en && (!dbg_halt || run_in_dbg);

   seg_scan_timer #(.DIV_W(DIV_W), .IDX_W(IDX_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .mod_en   (mod_en),
      .step     (step),
      .div_in   (lp_div),
      .last_idx (last_dig),
      .slice    (cur_slice),
      .idx      (cur_idx),
      .nxt_idx  (nxt_idx),
      .bound    (dig_bound)
   );

   seg_scan_bank #(.NUM_DIG(NUM_DIG), .SEG_W(SEG_W), .IDX_W(IDX_W)) i_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .mod_en   (mod_en),
      .wr_en    (wr_en),
      .wr_addr  (wr_addr),
      .wr_data  (wr_data),
      .bound    (dig_bound),
      .nxt_idx  (nxt_idx),
      .seg_hold (seg_hold)
   );

   seg_scan_drive #(.NUM_DIG(NUM_DIG), .SEG_W(SEG_W), .IDX_W(IDX_W)) i_drive (
      .mod_en      (mod_en),
      .com_mode    (com_mode),
      .com_off_hiz (com_off_hiz),
      .seg_off_hiz (seg_off_hiz),
      .bright      (bright),
      .slice       (cur_slice),
      .idx         (cur_idx),
      .seg_hold    (seg_hold),
      .com_o       (com_o),
      .com_oe      (com_oe),
      .seg_o       (seg_o),
      .seg_oe      (seg_oe)
   );
endmodule

// File: rtl/seg_scan_chk.sv
module seg_scan_chk #(
   parameter int NUM_DIG = 8,
   parameter int SEG_W   = 8,
   parameter int IDX_W   = 3,
   parameter int SLC_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic               clk_en,
   input logic               mod_en,
   input logic               dbg_halt,
   input logic               run_in_dbg,
   input logic               com_mode,
   input logic               com_off_hiz,
   input logic               seg_off_hiz,
   input logic [NUM_DIG-1:0] com_o,
   input logic [NUM_DIG-1:0] com_oe,
   input logic [SEG_W-1:0]   seg_o,
   input logic [SEG_W-1:0]   seg_oe,
   input logic [IDX_W-1:0]   idx,
   input logic [SLC_W-1:0]   slice,
   input logic               bound,
   input logic [SEG_W-1:0]   seg_hold
);
   logic [NUM_DIG-1:0] com_act;
   logic [SEG_W-1:0]   seg_act;
   logic               may_run;

   assign com_act = com_oe & (com_mode ? com_o : ~com_o);
   assign seg_act = seg_oe & (com_mode ? ~seg_o : seg_o);
   assign may_run = clk_en && (!dbg_halt || run_in_dbg);

   p_one_com_r3: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(com_act));

   p_seg_needs_com_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_act != '0) |-> (com_act != '0));

   p_dark_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !mod_en |-> (com_act == '0 && seg_act == '0));

   p_hold_dbg_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && !may_run) |=> ($stable(idx) && $stable(slice)));

   p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && $past(mod_en) && idx != $past(idx))
         |-> (idx == '0 || idx == IDX_W'($past(idx) + 1'b1)));

   p_com_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !com_off_hiz |-> (&com_oe));

   p_seg_drv_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !seg_off_hiz |-> (&seg_oe));

   p_seg_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (mod_en && !bound) |=> $stable(seg_hold));
endmodule

bind seg_scan_ctrl seg_scan_chk #(
   .NUM_DIG (NUM_DIG),
   .SEG_W   (SEG_W),
   .IDX_W   (IDX_W),
   .SLC_W   (seg_scan_pkg::SLICE_W)
) i_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .clk_en      (clk_en),
   .mod_en      (mod_en),
   .dbg_halt    (dbg_halt),
   .run_in_dbg  (run_in_dbg),
   .com_mode    (com_mode),
   .com_off_hiz (com_off_hiz),
   .seg_off_hiz (seg_off_hiz),
   .com_o       (com_o),
   .com_oe      (com_oe),
   .seg_o       (seg_o),
   .seg_oe      (seg_oe),
   .idx         (cur_idx),
   .slice       (cur_slice),
   .bound       (dig_bound),
   .seg_hold    (seg_hold)
);

// File: tb/test_seg_scan_ctrl.sv
module test_seg_scan_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       clk_en = 1'b1;
   logic       mod_en = 1'b0;
   logic       dbg_halt = 1'b0;
   logic       run_in_dbg = 1'b0;
   logic [7:0] lp_div = 8'd1;
   logic [2:0] last_dig = 3'd3;
   logic       com_mode = 1'b0;
   logic       com_off_hiz = 1'b0;
   logic       seg_off_hiz = 1'b0;
   logic [1:0] bright = 2'd3;
   logic       wr_en = 1'b0;
   logic [2:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   logic [7:0] com_o, com_oe, seg_o, seg_oe;

   int total = 0;
   int bad = 0;
   int pos = 0;
   int cfg_div = 1;
   int cfg_last = 3;
   logic [7:0] data [8];
   logic [7:0] view [8];

   always #10 clk = ~clk;

   seg_scan_ctrl i_seg_scan_ctrl (
      .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .mod_en(mod_en),
      .dbg_halt(dbg_halt), .run_in_dbg(run_in_dbg), .lp_div(lp_div),
      .last_dig(last_dig), .com_mode(com_mode), .com_off_hiz(com_off_hiz),
      .seg_off_hiz(seg_off_hiz), .bright(bright), .wr_en(wr_en),
      .wr_addr(wr_addr), .wr_data(wr_data), .com_o(com_o), .com_oe(com_oe),
      .seg_o(seg_o), .seg_oe(seg_oe)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s pos=%0d act=%h exp=%h", req, pos, act, exp);
      end
   endtask

   task automatic tick(input bit adv);
      @(posedge clk);
      #4;
      if (adv) pos++;
   endtask

   // expected outputs for digit d, slice e (dark forces all inactive)
   task automatic expect_de(input string req, input int d, input int e, input bit dark);
      logic [7:0] ca, sa, ec, ecoe, es, esoe;
      bit lit;
      lit = !dark && (e >= 3 - int'(bright));
      ca = lit ? (8'd1 << d) : 8'd0;
      sa = lit ? view[d] : 8'd0;
      ec   = com_mode ? ca : ~ca;
      ecoe = com_off_hiz ? ca : 8'hFF;
      es   = com_mode ? ~sa : sa;
      esoe = seg_off_hiz ? sa : 8'hFF;
      #1;
      chk(req, {com_o, com_oe, seg_o, seg_oe}, {ec, ecoe, es, esoe});
   endtask

   task automatic expect_now(input string req);
      int p;
      p = (cfg_div + 1) * 8;
      expect_de(req, (pos / p) % (cfg_last + 1), (pos % p) / (cfg_div + 1), 1'b0);
   endtask

   task automatic wr(input int a, input logic [7:0] v);
      wr_en = 1'b1; wr_addr = 3'(a); wr_data = v; data[a] = v;
      tick(mod_en);
      wr_en = 1'b0;
   endtask

   task automatic start(input int dv, input int last);
      mod_en = 1'b0;
      cfg_div = dv; cfg_last = last;
      lp_div = 8'(dv); last_dig = 3'(last);
      tick(0); tick(0);
      for (int i = 0; i < 8; i++) view[i] = data[i];
      mod_en = 1'b1;
      pos = 0;
   endtask

   task automatic run_chk(input string req, input int n);
      expect_now(req);
      for (int i = 0; i < n; i++) begin
         tick(1);
         expect_now(req);
      end
   endtask

   task automatic t_reset;
      for (int i = 0; i < 8; i++) view[i] = 8'h00;
      expect_de("R11", 0, 0, 1'b1);
      chk("R11", {com_o, seg_o}, {8'hFF, 8'h00});
   endtask

   task automatic t_load;
      wr(0, 8'h3F); wr(1, 8'h06); wr(2, 8'h5B); wr(3, 8'h4F);
      wr(4, 8'h66); wr(5, 8'h6D); wr(6, 8'h7D); wr(7, 8'h87);
   endtask

   task automatic t_scan;   // R1 R2 R3
      start(1, 3);
      run_chk("R2", 160);
   endtask

   task automatic t_period;   // R1 boundary and full eight-digit wrap
      start(4, 7);
      run_chk("R1", 330);
   endtask

   task automatic t_single;   // R2 with one digit
      start(0, 0);
      run_chk("R2", 40);
   endtask

   task automatic t_bright;   // R7
      for (int b = 0; b < 3; b++) begin
         bright = 2'(b);
         start(1, 1);
         run_chk("R7", 40);
      end
      bright = 2'd3;
   endtask

   task automatic t_polarity;   // R5
      com_mode = 1'b1;
      start(1, 2);
      run_chk("R5", 50);
      com_mode = 1'b0;
   endtask

   task automatic t_hiz;   // R6
      com_off_hiz = 1'b1; seg_off_hiz = 1'b1;
      start(1, 2);
      run_chk("R6", 50);
      com_mode = 1'b1; bright = 2'd2;
      start(0, 3);
      run_chk("R6", 40);
      com_mode = 1'b0; bright = 2'd3;
      com_off_hiz = 1'b0; seg_off_hiz = 1'b0;
   endtask

   task automatic t_debug;   // R4: halt lands on the digit boundary cycle
      start(1, 3);
      run_chk("R4", 15);
      dbg_halt = 1'b1;
      expect_now("R4");
      for (int i = 0; i < 10; i++) begin
         tick(0);
         expect_now("R4");
      end
      dbg_halt = 1'b0;
      run_chk("R4", 25);
      run_in_dbg = 1'b1; dbg_halt = 1'b1;
      run_chk("R4", 20);
      clk_en = 1'b0;
      for (int i = 0; i < 3; i++) begin
         tick(0);
         expect_now("R4");
      end
      clk_en = 1'b1; dbg_halt = 1'b0; run_in_dbg = 1'b0;
      run_chk("R4", 10);
   endtask

   task automatic t_disable;   // R8
      start(1, 3);
      run_chk("R8", 20);
      mod_en = 1'b0;
      expect_de("R8", 0, 0, 1'b1);
      tick(0);
      expect_de("R8", 0, 0, 1'b1);
      tick(0);
      mod_en = 1'b1;
      pos = 0;
      run_chk("R8", 20);
   endtask

   task automatic t_midcfg;   // R9
      start(1, 3);
      run_chk("R9", 5);
      lp_div = 8'd3;
      while (pos < 48) begin
         tick(1);
         if (pos == 15) expect_de("R9", 0, 7, 1'b0);
         if (pos == 16) expect_de("R9", 1, 0, 1'b0);
         if (pos == 47) expect_de("R9", 1, 7, 1'b0);
      end
      expect_de("R9", 2, 0, 1'b0);
      start(1, 3);
      run_chk("R9", 20);
      last_dig = 3'd1;
      while (pos < 64) begin
         tick(1);
         if (pos == 31) expect_de("R9", 1, 7, 1'b0);
         if (pos == 32) expect_de("R9", 0, 0, 1'b0);
         if (pos == 48) expect_de("R9", 1, 0, 1'b0);
      end
      expect_de("R9", 0, 0, 1'b0);
   endtask

   task automatic t_sample;   // R10
      start(1, 1);
      run_chk("R10", 3);
      wr(0, 8'h71);
      wr(1, 8'h79);
      while (pos < 15) begin
         expect_now("R10");
         tick(1);
      end
      expect_now("R10");
      tick(1);
      view[1] = 8'h79;
      expect_now("R10");
      while (pos < 32) tick(1);
      view[0] = 8'h71;
      expect_now("R10");
   endtask

   initial begin
      for (int i = 0; i < 8; i++) data[i] = 8'h00;
      #35;
      rst_n = 1'b1;
      tick(0);
      t_reset();
      t_load();
      t_scan();
      t_period();
      t_single();
      t_bright();
      t_polarity();
      t_hiz();
      t_debug();
      t_disable();
      t_midcfg();
      t_sample();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(200000 * 20);
      total++;
      bad++;
      $display("FAIL watchdog pos=%0d act=running exp=finished", pos);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule